// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the byte-level front end of an I2C target. It watches the open-drain SCL and SDA lines with a fast system clock and finds START and STOP conditions. It compares the first byte of every transaction against a device address, acknowledges when the address matches, and then moves whole bytes between the serial bus and a simple parallel interface. Received bytes come out with a one-cycle valid strobe. Bytes to send are fetched with a one-cycle request strobe. The pad is modelled as an SDA input plus a drive-low output.

The address byte has no direction bit. Its upper nibble is the fixed pattern 0101 and its lower nibble comes from four strap inputs, so up to sixteen targets can share a bus. The surrounding logic selects the direction with `read_mode_i`. The block samples this input when the address acknowledge ends. Command decoding and the storage behind the bytes are not part of this block.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, or after a mismatch, the block ignores all SCL/SDA activity and never drives SDA until a START is seen. A START is SDA falling while SCL is high.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. A following byte without a new START is not acknowledged.
- R3: The first byte after START is taken MSB first. It matches when bits 7..4 equal 0101 and bits 3..0 equal `strap_i[3:0]`. On a match the block pulls SDA low during the ninth SCL clock.
- R4: On a non-matching address byte the block leaves SDA released on the ninth clock. It does not acknowledge or strobe any later byte until the next START.
- R5: When the block is selected with `read_mode_i` low, it acknowledges every further 8-bit byte. It pulses `rx_valid_o` for one cycle per byte with the byte (MSB first) on `rx_data_o`, in the same cycle the acknowledge drive starts.
- R6: When `read_mode_i` is high at the end of the address acknowledge, the block pulses `tx_req_o` for one cycle. It captures `tx_data_i` on the clock edge that ends that pulse and shifts the byte out MSB first. SDA drive changes only while SCL is low.
- R7: In read mode the block releases SDA for the ninth clock and samples it. A low level (master acknowledge) gives a new `tx_req_o` pulse and the next byte is sent.
- R8: If the master leaves SDA high on the ninth clock of a read, the block keeps SDA released and requests no more bytes until a STOP or START.
- R9: A START in the middle of a byte aborts that byte without a strobe and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| strap_i | input | STRAP_W | Address strap bits |
| read_mode_i | input | 1 | Selects read direction after the address acknowledge |
| rx_data_o | output | DATA_W | Last received write byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_data_i | input | DATA_W | Next byte to transmit |
| tx_req_o | output | 1 | One-cycle request for tx_data_i |

## Verification
The checker watches several properties on every cycle. A detected START always leads to address matching, and a STOP always leads to idle with SDA released. The drive-low output never rises or falls while the synchronized SCL is high. Each receive strobe comes with an acknowledge drive, and both strobes are single-cycle and never coincide. Some behaviour depends on whole bus transactions, and only the bench scenarios show it. These are the address compare against random straps, correct byte values in both directions, and the ignored traffic after a mismatch, a STOP or a master not-acknowledge. They also include the abort of a partial byte by a repeated START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_HOLD
  } tgt_state_e;

  localparam logic [3:0] ADDR_PREFIX = 4'b0101;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;  // idle bus is high
      else         pipe <= {pipe[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_q_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q_o <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      scl_q_o <= scl_s_i;
      sda_q   <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q_o;
  assign scl_fall_o = ~scl_s_i & scl_q_o;
  assign start_o    = scl_s_i & scl_q_o & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q_o & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int STRAP_W     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic              read_mode_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_req_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic scl_s, sda_s, scl_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] own_addr;
  logic [CNT_W-1:0]  cnt;
  logic              nine_hi, ack_ok;
  tgt_state_e        state_q;

  assign own_addr = {ADDR_PREFIX, strap_i};

  i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_tgt_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_q_o   (scl_q),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      sda_drive_o <= 1'b0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      tx_req_o    <= 1'b0;
      nine_hi     <= 1'b0;
      ack_ok      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_req_o   <= 1'b0;
      if (bus_start) begin
        state_q     <= ST_ADDR;
        cnt         <= '0;
        nine_hi     <= 1'b0;
        sda_drive_o <= 1'b0;
      end else if (bus_stop) begin
        state_q     <= ST_IDLE;
        sda_drive_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt     <= '0;
              nine_hi <= 1'b0;
              if (state_q == ST_WR) begin
                sda_drive_o <= 1'b1;
                rx_data_o   <= shreg;
                rx_valid_o  <= 1'b1;
                state_q     <= ST_WR_ACK;
              end else if (shreg == own_addr) begin
                sda_drive_o <= 1'b1;
                state_q     <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_rise) nine_hi <= 1'b1;
            if (scl_fall && nine_hi) begin
              nine_hi     <= 1'b0;
              sda_drive_o <= 1'b0;
              if (state_q == ST_ADDR_ACK && read_mode_i) begin
                state_q  <= ST_RD;
                tx_req_o <= 1'b1;
              end else begin
                state_q <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (tx_req_o) begin
              shreg       <= tx_data_i;
              sda_drive_o <= ~tx_data_i[DATA_W-1];
              cnt         <= '0;
            end else if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_drive_o <= 1'b0;
                nine_hi     <= 1'b0;
                state_q     <= ST_RD_ACK;
              end else begin
                shreg       <= {shreg[DATA_W-2:0], 1'b0};
                sda_drive_o <= ~shreg[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nine_hi <= 1'b1;
              ack_ok  <= ~sda_s;
            end
            if (scl_fall && nine_hi) begin
              nine_hi <= 1'b0;
              if (ack_ok) begin
                tx_req_o <= 1'b1;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
          default: ;  // idle and hold wait for START/STOP
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_q,
  input logic       bus_start,
  input logic       bus_stop,
  input tgt_state_e state_q,
  input logic       sda_drive_o,
  input logic       rx_valid_o,
  input logic       tx_req_o
);
  assert_start_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start |=> state_q == ST_ADDR);

  assert_stop_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stop && !bus_start) |=> (state_q == ST_IDLE && !sda_drive_o));

  assert_rx_with_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sda_drive_o);

  assert_rx_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_drive_rise_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_o) |-> !scl_q);

  assert_drive_fall_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_drive_o) |-> !scl_q);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_o, tx_req_o}));

  assert_req_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_q      (scl_q),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .state_q    (state_q),
  .sda_drive_o(sda_drive_o),
  .rx_valid_o (rx_valid_o),
  .tx_req_o   (tx_req_o)
);

// File: tb/i2c_tgt_test.sv
module i2c_tgt_test;
  localparam int H = 10;  // system cycles per SCL phase

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_drive;
  logic [3:0] strap = 4'h0;
  logic       read_mode = 1'b0;
  logic [7:0] rx_data, tx_data;
  logic       rx_valid, tx_req;
  wire        sda_line = sda_m & ~sda_drive;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] tx_mem [16];
  int         tx_idx = 0;
  logic [7:0] rx_log [256];
  int         rx_cnt = 0;

  always #2 clk = ~clk;

  i2c_tgt uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_o(sda_drive), .strap_i(strap), .read_mode_i(read_mode),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_data_i(tx_data), .tx_req_o(tx_req)
  );

  assign tx_data = tx_mem[tx_idx % 16];

  always @(posedge clk) begin
    if (tx_req) tx_idx <= tx_idx + 1;
    if (rx_valid) begin
      rx_log[rx_cnt % 256] <= rx_data;
      rx_cnt <= rx_cnt + 1;
    end
  end

  function automatic logic [7:0] addr_of(logic [3:0] s);
    return {4'b0101, s};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; wt(H/2); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H/2); b = sda_line; wt(H/2);
    scl_m = 1'b0; wt(H/2);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H/2); sda_m = 1'b0; wt(H/2);
    scl_m = 1'b0; wt(H/2);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(H/2); scl_m = 1'b1; wt(H/2); sda_m = 1'b1; wt(H);
  endtask

  task automatic wr_byte(logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic rd_byte(bit m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!m_ack);
  endtask

  task automatic txn_write(int n);
    bit a;
    logic [7:0] d;
    int base = rx_cnt;
    read_mode = 1'b0;
    do_start();
    wr_byte(addr_of(strap), a);
    check(a, "R3", a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wr_byte(d, a);
      check(a, "R5 ack", a, 1);
      wt(1);
      check(rx_log[(base + k) % 256] == d, "R5 data", rx_log[(base + k) % 256], d);
    end
    check(rx_cnt == base + n, "R5 count", rx_cnt, base + n);
    do_stop();
  endtask

  task automatic txn_read(int n);
    bit a;
    logic [7:0] d;
    logic b;
    int base = tx_idx;
    read_mode = 1'b1;
    do_start();
    wr_byte(addr_of(strap), a);
    check(a, "R3", a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      check(d == tx_mem[(base + k) % 16], k == 0 ? "R6" : "R7", d, tx_mem[(base + k) % 16]);
    end
    check(tx_idx == base + n, "R8 requests", tx_idx, base + n);
    for (int i = 0; i < 8; i++) begin
      bit_in(b);
      check(b == 1'b1, "R8 released", b, 1);
    end
    check(tx_idx == base + n, "R8 no request", tx_idx, base + n);
    do_stop();
    read_mode = 1'b0;
  endtask

  task automatic txn_bad(logic [7:0] ad);
    bit a;
    int base = rx_cnt;
    do_start();
    wr_byte(ad, a);
    check(!a, "R4 addr", a, 0);
    for (int k = 0; k < 2; k++) begin
      wr_byte(addr_of(strap), a);
      check(!a, "R4 later", a, 0);
    end
    check(rx_cnt == base, "R4 strobe", rx_cnt, base);
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] bad, d;
    int base;
    void'($urandom(32'h1c2d));
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'($urandom);
    wt(5);
    check(!sda_drive && !rx_valid && !tx_req, "R1 reset", {sda_drive, rx_valid, tx_req}, 0);
    rst_n = 1'b1;
    wt(5);

    // R1: traffic without START is ignored
    strap = 4'h9;
    scl_m = 1'b0; wt(H);
    wr_byte(addr_of(strap), a);
    check(!a, "R1 no start", a, 0);
    do_stop();

    // R2: after STOP, address without START is ignored
    txn_write(1);
    scl_m = 1'b0; wt(H);
    wr_byte(addr_of(strap), a);
    check(!a, "R2 after stop", a, 0);
    do_stop();

    // R4: directed prefix and strap mismatches
    txn_bad({4'b0100, strap});
    txn_bad({4'b0101, strap ^ 4'h1});

    // R9: repeated START aborts a partial byte
    base = rx_cnt;
    do_start();
    wr_byte(addr_of(strap), a);
    check(a, "R9 first addr", a, 1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    do_start();
    check(rx_cnt == base, "R9 no strobe", rx_cnt, base);
    wr_byte(addr_of(strap), a);
    check(a, "R9 readdress", a, 1);
    d = 8'hC3;
    wr_byte(d, a);
    wt(1);
    check(rx_cnt == base + 1 && rx_log[base % 256] == d, "R9 byte", rx_log[base % 256], d);
    do_stop();

    // random mix
    for (int t = 0; t < 40; t++) begin
      strap = 4'($urandom);
      case ($urandom % 3)
        0: txn_write(1 + int'($urandom % 4));
        1: txn_read(1 + int'($urandom % 4));
        default: begin
          do bad = 8'($urandom); while (bad == addr_of(strap));
          txn_bad(bad);
        end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule